// File: doc/BRIEF.md
# Packed Saturating Integer Adder

This unit adds or subtracts two 64-bit words that are split into equal independent lanes. A two-bit lane-size select sets the split: eight byte lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane performs the same operation in the same cycle. No carry or borrow passes from one lane into the next, so a full byte-packed operation completes in one pass.

Each operation either wraps modulo the lane width or clamps to the lane's limits. Clamping can be unsigned or signed, and it applies only to 8-bit and 16-bit lanes. A clamped lane gives no carry or overflow flag; the clamped value is the whole result. The result is registered, and an output valid strobe marks it one clock after the input valid strobe.

Top module: `pack_sat_adder`

## Requirements
- R1: `laneSel` encodes the packing as 00 = eight 8-bit lanes, 01 = four 16-bit lanes, 10 = two 32-bit lanes and 11 = one 64-bit lane. Lane k occupies bits [k*w+w-1 : k*w] for lane width w.
- R2: In wrapping addition each lane gives (a + b) mod 2^w, and no carry enters the neighbouring lane.
- R3: In wrapping subtraction each lane gives (a - b) mod 2^w, and no borrow enters the neighbouring lane.
- R4: In unsigned clamped addition a lane sum above 2^w - 1 is replaced by 2^w - 1; for example, byte lanes computing 200 + 100 give 255.
- R5: In unsigned clamped subtraction a lane difference below zero is replaced by 0.
- R6: In signed clamped mode (`signedSat` = 1) the lane is read as two's complement, and an out-of-range result becomes 2^(w-1) - 1 or -2^(w-1); for byte lanes these are 127 and -128.
- R7: A clamping opcode used with 32-bit or 64-bit lanes gives the same result as the matching wrapping opcode.
- R8: `opCode` encodes 00 = add-wrap, 01 = add-clamp, 10 = subtract-wrap, 11 = subtract-clamp, and `signedSat` has no effect on the wrapping opcodes.
- R9: `outValid` equals `inValid` delayed by exactly one clock. A synchronous reset clears `outValid` and `result` to 0.
- R10: `result` holds its last value in any cycle that follows a cycle with `inValid` low.
- R11: Operations presented on consecutive cycles each produce their own correct result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands and controls are valid this cycle |
| laneSel | input | 2 | Lane packing select |
| opCode | input | 2 | Add/subtract and wrap/clamp select |
| signedSat | input | 1 | Clamp as signed (1) or unsigned (0) |
| opA | input | 64 | First operand, minuend for subtraction |
| opB | input | 64 | Second operand, subtrahend for subtraction |
| outValid | output | 1 | Result is valid |
| result | output | 64 | Registered packed result |

## Verification
The embedded properties assume that the inputs carry no X or Z while `inValid` is high, and that `rst` is held for at least one edge before the first transfer. The byte-lane ceiling and floor properties compare against the previous cycle's `opA`. The bench therefore sets every operand and control together on a falling edge and changes them only on the next falling edge. It drops `inValid` for a reset or a hold pause only after the pending results have left the register.

// File: rtl/pksat_pkg.sv
package pksat_pkg;
  localparam int DATA_W     = 64;
  localparam int SLICE_W    = 8;
  localparam int NUM_SLICES = DATA_W / SLICE_W;
  localparam int IDX_W      = $clog2(NUM_SLICES);

  typedef enum logic [1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } laneSize_e;

  // strobes sent from the decoder to the arithmetic slices
  typedef struct packed {
    logic                  doSub;
    logic                  doSat;
    logic                  isSigned;
    logic                  pairLanes;
    logic [NUM_SLICES-1:0] laneStart;
  } ctrlStrobes_t;
endpackage

// File: rtl/pksat_ctrl.sv
module pksat_ctrl
  import pksat_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   laneSel,
  input  logic [1:0]   opCode,
  input  logic         signedSat,
  output ctrlStrobes_t strobes
);
  logic [IDX_W-1:0] laneMask;

  always_comb begin
    laneMask          = IDX_W'((1 << laneSel) - 1);
    strobes.doSub     = opCode[1];
    strobes.doSat     = opCode[0] && (laneSel == LANE_8 || laneSel == LANE_16);
    strobes.isSigned  = signedSat;
    strobes.pairLanes = (laneSel == LANE_16);
    for (int i = 0; i < NUM_SLICES; i++) begin
      strobes.laneStart[i] = ((IDX_W'(i) & laneMask) == '0);
    end
  end

  AST_SAT_NARROW_ONLY: assert property (@(posedge clk) disable iff (rst)
    laneSel[1] |-> !strobes.doSat); // R7

  AST_LANE_FIRST_SLICE: assert property (@(posedge clk) disable iff (rst)
    strobes.laneStart[0] && ($countones(strobes.laneStart) == (NUM_SLICES >> laneSel))); // R1
endmodule

// File: rtl/pksat_dp.sv
module pksat_dp
  import pksat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  ctrlStrobes_t      strobes,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  logic [SLICE_W-1:0]    bEff [NUM_SLICES];
  logic [SLICE_W-1:0]    sumS [NUM_SLICES];
  logic [NUM_SLICES-1:0] coutS;
  logic [NUM_SLICES-1:0] msbCin;
  logic [DATA_W-1:0]     satWord;

  // carry chain, cut wherever a lane begins
  for (genvar g = 0; g < NUM_SLICES; g++) begin : gSlice
    logic cinS;
    assign bEff[g] = strobes.doSub ? ~opB[g*SLICE_W +: SLICE_W] : opB[g*SLICE_W +: SLICE_W];
    if (g == 0) begin : gFirst
      assign cinS = strobes.laneStart[0] ? strobes.doSub : 1'b0;
    end else begin : gRest
      assign cinS = strobes.laneStart[g] ? strobes.doSub : coutS[g-1];
    end
    assign {coutS[g], sumS[g]} = {1'b0, opA[g*SLICE_W +: SLICE_W]} + {1'b0, bEff[g]}
                                 + {{SLICE_W{1'b0}}, cinS};
    assign msbCin[g] = opA[g*SLICE_W + SLICE_W - 1] ^ bEff[g][SLICE_W-1] ^ sumS[g][SLICE_W-1];
  end

  // per-slice clamp, using the flags of the slice that holds the lane's top
  for (genvar g = 0; g < NUM_SLICES; g++) begin : gSat
    localparam int  TOP_PAIR = g | 1;
    localparam bit  IS_ODD   = (g % 2) == 1;
    logic topCout, topMsbCin, topNeg, isTop, ovfU, ovfS;
    logic [SLICE_W-1:0] sliceOut;

    assign topCout   = strobes.pairLanes ? coutS[TOP_PAIR]  : coutS[g];
    assign topMsbCin = strobes.pairLanes ? msbCin[TOP_PAIR] : msbCin[g];
    assign topNeg    = strobes.pairLanes ? opA[TOP_PAIR*SLICE_W + SLICE_W - 1]
                                         : opA[g*SLICE_W + SLICE_W - 1];
    assign isTop     = !strobes.pairLanes || IS_ODD;
    assign ovfU      = topCout ^ strobes.doSub;
    assign ovfS      = topCout ^ topMsbCin;

    always_comb begin
      sliceOut = sumS[g];
      if (strobes.doSat) begin
        if (strobes.isSigned && ovfS) begin
          sliceOut = isTop ? {topNeg, {(SLICE_W-1){~topNeg}}} : {SLICE_W{~topNeg}};
        end else if (!strobes.isSigned && ovfU) begin
          sliceOut = {SLICE_W{~strobes.doSub}};
        end
      end
    end
    assign satWord[g*SLICE_W +: SLICE_W] = sliceOut;

    AST_USAT_ADD_CEIL: assert property (@(posedge clk) disable iff (rst)
      (inValid && strobes.doSat && !strobes.isSigned && !strobes.doSub && !strobes.pairLanes)
      |=> (result[g*SLICE_W +: SLICE_W] >= $past(opA[g*SLICE_W +: SLICE_W]))); // R4

    AST_USAT_SUB_FLOOR: assert property (@(posedge clk) disable iff (rst)
      (inValid && strobes.doSat && !strobes.isSigned && strobes.doSub && !strobes.pairLanes)
      |=> (result[g*SLICE_W +: SLICE_W] <= $past(opA[g*SLICE_W +: SLICE_W]))); // R5
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) result <= satWord;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R9

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R9

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result)); // R10
endmodule

// File: rtl/pack_sat_adder.sv
module pack_sat_adder
  import pksat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        laneSel,
  input  logic [1:0]        opCode,
  input  logic              signedSat,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  ctrlStrobes_t strobes;

  pksat_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .laneSel   (laneSel),
    .opCode    (opCode),
    .signedSat (signedSat),
    .strobes   (strobes)
  );

  pksat_dp uDp (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .outValid (outValid),
    .result   (result)
  );
endmodule

// File: tb/pack_sat_adder_test.sv
`timescale 1ns/1ps
module pack_sat_adder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  laneSel = 2'b00;
  logic [1:0]  opCode = 2'b00;
  logic        signedSat = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;

  pack_sat_adder uut (
    .clk(clk), .rst(rst), .inValid(inValid), .laneSel(laneSel), .opCode(opCode),
    .signedSat(signedSat), .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    logic [63:0] val;
    int          issued;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  logic [63:0] lastRes = '0;
  bit          haveRes = 1'b0;
  bit          monOn   = 1'b0;

  task automatic checkVal(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // reference: lane by lane from the requirements
  function automatic logic [63:0] refModel(input logic [63:0] a, input logic [63:0] b,
                                           input logic [1:0] op, input logic [1:0] sz,
                                           input logic sg);
    int w = 8 << sz;
    int n = 64 / w;
    logic [63:0] res = '0;
    for (int k = 0; k < n; k++) begin
      logic [64:0] x, y, m, r;
      longint sx, sy, sr, hi, lo;
      m = (65'd1 << w) - 65'd1;
      x = ({1'b0, a} >> (k*w)) & m;
      y = ({1'b0, b} >> (k*w)) & m;
      if (op[0] && w <= 16) begin
        if (!sg) begin
          if (!op[1]) begin
            r = x + y;
            if (r > m) r = m;
          end else begin
            r = (x < y) ? 65'd0 : x - y;
          end
        end else begin
          sx = longint'(x);
          sy = longint'(y);
          if (x[w-1]) sx = sx - (longint'(1) << w);
          if (y[w-1]) sy = sy - (longint'(1) << w);
          sr = op[1] ? sx - sy : sx + sy;
          hi = (longint'(1) << (w-1)) - 1;
          lo = -hi - 1;
          if (sr > hi) sr = hi;
          if (sr < lo) sr = lo;
          r = 65'(sr) & m;
        end
      end else begin
        r = (op[1] ? x - y : x + y) & m;
      end
      res = res | (r[63:0] << (k*w));
    end
    return res;
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op,
                       input logic [1:0] sz, input logic sg, input string tag);
    exp_t it;
    @(negedge clk);
    opA = a; opB = b; opCode = op; laneSel = sz; signedSat = sg; inValid = 1'b1;
    it.val = refModel(a, b, op, sz, sg);
    it.issued = cyc;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = ~opA;
      opB = opB + 64'h1234;
    end
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (monOn && !rst) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9 got unexpected outValid=1 expected 0");
        end else begin
          exp_t it;
          it = expQ.pop_front();
          checkVal(it.tag, result, it.val);
          checkVal("R9 latency", 64'(cyc), 64'(it.issued + 1));
          lastRes = result;
          haveRes = 1'b1;
        end
      end else if (haveRes) begin
        checkVal("R10 hold", result, lastRes);
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog got hung expected completion");
    finishRun();
  end

  initial begin
    logic [63:0] lf;
    repeat (3) @(negedge clk);
    checkVal("R9 reset outValid", 64'(outValid), 64'd0);
    checkVal("R9 reset result", result, 64'd0);
    rst = 1'b0;
    monOn = 1'b1;

    // R4: 200 + 100 clamps to 255 in every byte; mixed bytes
    drive(64'hC8C8C8C8C8C8C8C8, 64'h6464646464646464, 2'b01, 2'b00, 1'b0, "R4 byte ceil");
    drive(64'h00FF10F0807F0102, 64'h0001F0200180FEFE, 2'b01, 2'b00, 1'b0, "R4 byte mix");
    drive(64'hFFF0000180000001, 64'h0020FFFF80000002, 2'b01, 2'b01, 1'b0, "R4 word ceil");
    // R5: unsigned floor
    drive(64'h1020304050607080, 64'h2010405060507090, 2'b11, 2'b00, 1'b0, "R5 byte floor");
    drive(64'h0010FFFF00010000, 64'h0020000100020001, 2'b11, 2'b01, 1'b0, "R5 word floor");
    // R6: signed clamps
    drive(64'h7F80807F7F80407F, 64'h01FF0181FF01C080, 2'b01, 2'b00, 1'b1, "R6 byte add");
    drive(64'h7F80807F00800001, 64'hFF0101FF7F010203, 2'b11, 2'b00, 1'b1, "R6 byte sub");
    drive(64'h7FFF800012348000, 64'h0001FFFF7000FFFF, 2'b01, 2'b01, 1'b1, "R6 word add");
    drive(64'h80007FFF0001FFFE, 64'h0001FFFF80007FFF, 2'b11, 2'b01, 1'b1, "R6 word sub");
    // R2 / R1: wrap add, carries stop at each lane edge
    drive(64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101, 2'b00, 2'b00, 1'b0, "R2 byte wrap");
    drive(64'hFFFFFFFFFFFFFFFF, 64'h0001000100010001, 2'b00, 2'b01, 1'b0, "R2 word wrap");
    drive(64'hFFFFFFFFFFFFFFFF, 64'h0000000100000001, 2'b00, 2'b10, 1'b0, "R1 dword wrap");
    drive(64'h00000000FFFFFFFF, 64'h0000000000000001, 2'b00, 2'b11, 1'b0, "R1 qword carry");
    // R3: wrap subtract, borrows stay inside the lane
    drive(64'h0000000000000000, 64'h0101010101010101, 2'b10, 2'b00, 1'b0, "R3 byte borrow");
    drive(64'h0000000000000000, 64'h0000000100000001, 2'b10, 2'b10, 1'b0, "R3 dword borrow");
    drive(64'h0000000000000000, 64'h0000000000000001, 2'b10, 2'b11, 1'b0, "R3 qword borrow");
    // R7: clamp opcode on wide lanes wraps
    drive(64'hFFFFFFFF7FFFFFFF, 64'h0000000200000001, 2'b01, 2'b10, 1'b0, "R7 dword addclamp");
    drive(64'h0000000080000000, 64'h0000000100000001, 2'b11, 2'b10, 1'b1, "R7 dword subclamp");
    drive(64'hFFFFFFFFFFFFFFFF, 64'h0000000000000005, 2'b01, 2'b11, 1'b1, "R7 qword addclamp");
    // R8: signed bit ignored for wrapping opcodes
    drive(64'h7F7F7F7F7F7F7F7F, 64'h0101010101010101, 2'b00, 2'b00, 1'b1, "R8 wrap signed");
    drive(64'h8000800080008000, 64'h0001000100010001, 2'b10, 2'b01, 1'b1, "R8 subwrap signed");
    idle(3);

    // R11: back-to-back mixed stream
    lf = 64'hACE1_2468_1357_9BDF;
    for (int i = 0; i < 48; i++) begin
      logic [63:0] a, b;
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      a = lf;
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      b = {lf[31:0], lf[63:32]};
      drive(a, b, lf[1:0], lf[3:2], lf[4], "R11 stream");
      if (i == 20) idle(2);
    end
    idle(4);

    // R9: mid-run reset clears the output register
    haveRes = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b1;
    opA = 64'h1111111111111111;
    opB = 64'h2222222222222222;
    @(negedge clk);
    checkVal("R9 midreset outValid", 64'(outValid), 64'd0);
    checkVal("R9 midreset result", result, 64'd0);
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    drive(64'h0102030405060708, 64'h1010101010101010, 2'b00, 2'b00, 1'b0, "R9 after reset");
    idle(4);

    checkVal("R11 queue drained", 64'(expQ.size()), 64'd0);
    finishRun();
  end
endmodule